// File: doc/BRIEF.md
# Tri-Linear CCD Line Timing Generator

This block produces the digital clocking for a three-colour linear CCD imager that has one readout register per colour, all shifted together. A start strobe opens one line. The line has two parts. First comes a transfer part: the register clocks are frozen, and the two transfer gates move the integrated charge from the photodiodes into the registers. Then comes a readout part. Complementary register clocks shift out the light-shielded dark pixels first and then the active pixels. A sense-node reset pulse comes before every packet, and two window flags mark when downstream sampling should take place.

Each colour has its own exposure gate. The gate is high while the first transfer gate turns off, and it falls a programmed number of pixel-clock periods before the end of the line. This sets the integration time of that colour. The last register gate has its own output. In full-resolution mode it follows the second register phase. In two-pixel summing mode it collects two shifts into one packet, and the reset pulse and valid flag then come once per pair.

The summing select and the three exposure values are captured when a line starts and are held for the whole line. A start strobe that arrives while a line is running is ignored.

Top module: `ccd_tri_timing`

## Requirements
- R1: After reset and while no line is running: `reg_ph1`=1, `reg_ph2`=0, and every other output is 0. A line starts on the clock edge that samples `line_start`=1 in idle. Its first tick appears on the outputs after that edge. After the last readout tick the block is idle for at least one cycle. `line_start` has no effect while a line runs.
- R2: The transfer part is 4*SEG_TICKS ticks long, split into four segments of SEG_TICKS ticks each. Segment 0: both gates low. Segment 1: `xfer_g1`=1 and `xfer_g2`=1. Segment 2: only `xfer_g2`=1. Segment 3: both gates low. `reg_ph1`=1 and `reg_ph2`=0 throughout.
- R3: The readout part is 2*(N_DARK+N_ACTIVE) ticks long, two ticks per register shift. In the first tick of a shift `reg_ph2`=1 and `reg_ph1`=0. In the second tick the two are swapped.
- R4: In full-resolution mode (`sum_mode`=0 at start) `node_rst` is high for exactly the first tick of every shift.
- R5: A sample window is the second tick of a shift in full mode. In summing mode it is the fourth tick of a shift pair. A window is flagged on `dark_valid` for shifts 0..N_DARK-1 and on `pix_valid` for the later shifts. The two flags are never high together.
- R6: In full-resolution mode `last_gate` equals `reg_ph2` on every cycle.
- R7: In summing mode (`sum_mode`=1 at start) `last_gate` has a period of four readout ticks: high for three ticks, then low for one. `node_rst` is high only in the third tick of each pair. A line then gives N_ACTIVE/2 active and N_DARK/2 dark windows.
- R8: For a channel with exposure value E (1 ≤ E ≤ readout length), `exp_gate` is high during the whole transfer part. It then stays high up to readout tick 2*(N_DARK+N_ACTIVE)-E, and falls on a register phase edge. Over a line it is therefore high for 4*SEG_TICKS+2*(N_DARK+N_ACTIVE)-E cycles.
- R9: An exposure value above the readout length acts as the readout length, so the gate is high only during transfer. A value of 0 keeps that gate low for the whole line.
- R10: The three exposure gates are independent: index 0 follows `exp_red`, index 1 follows `exp_grn` and index 2 follows `exp_blu`. Changes to `sum_mode` or to the exposure inputs during a line do not affect that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Starts one line when sampled high in idle |
| sum_mode | input | 1 | 1 selects two-pixel summing, captured at line start |
| exp_red | input | EXP_W | Exposure of channel 0 in ticks, captured at line start |
| exp_grn | input | EXP_W | Exposure of channel 1 in ticks, captured at line start |
| exp_blu | input | EXP_W | Exposure of channel 2 in ticks, captured at line start |
| reg_ph1 | output | 1 | Register phase 1 |
| reg_ph2 | output | 1 | Register phase 2 |
| last_gate | output | 1 | Last register gate clock (summing gate) |
| xfer_g1 | output | 1 | Transfer gate 1 |
| xfer_g2 | output | 1 | Transfer gate 2 |
| node_rst | output | 1 | Sense-node reset pulse |
| exp_gate | output | 3 | Per-channel exposure gate |
| pix_valid | output | 1 | Active-pixel sample window |
| dark_valid | output | 1 | Dark-reference sample window |

## Verification
The hardest case to reach is an input change in the middle of a line. A new start strobe, a flip of the summing select, or new exposure values all arrive while the captured settings must stay in force. From the ports this can be seen only when the changes land well inside the readout part. The stimulus therefore waits a fixed number of ticks after the start, rewrites every input and pulses the start strobe there. It then counts the windows and the exposure-gate high cycles for the whole line against the values captured at the start. A second case holds the start strobe high without a break, so that one line follows another with only the single idle cycle between them. Exposure values of 0, of 1, exactly equal to the readout length, and above it drive the clamp and the hold-low paths.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_XFER = 2'd1,
    PH_READ = 2'd2
  } line_phase_t;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tg_pkg::*;
#(
  parameter int XFER_TICKS = 16,
  parameter int READ_TICKS = 4220,
  parameter int CW         = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output line_phase_t   phase_n,
  output logic [CW-1:0] cnt_n
);
  localparam logic [CW-1:0] XFER_LAST = CW'(XFER_TICKS - 1);
  localparam logic [CW-1:0] READ_LAST = CW'(READ_TICKS - 1);

  line_phase_t   phase_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    load    = 1'b0;
    phase_n = phase_q;
    cnt_n   = cnt_q + 1'b1;
    case (phase_q)
      PH_IDLE: begin
        cnt_n = '0;
        if (start) begin
          load    = 1'b1;
          phase_n = PH_XFER;
        end
      end
      PH_XFER: begin
        if (cnt_q == XFER_LAST) begin
          phase_n = PH_READ;
          cnt_n   = '0;
        end
      end
      PH_READ: begin
        if (cnt_q == READ_LAST) begin
          phase_n = PH_IDLE;
          cnt_n   = '0;
        end
      end
      default: begin
        phase_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  // R1
  read_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_READ && cnt_q == READ_LAST) |=> (phase_q == PH_IDLE));

  // R2
  xfer_to_read_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_XFER && cnt_q == XFER_LAST) |=> (phase_q == PH_READ && cnt_q == '0));
endmodule

// File: rtl/ccd_clock_gen.sv
module ccd_clock_gen
  import ccd_tg_pkg::*;
#(
  parameter int N_DARK    = 12,
  parameter int N_ACTIVE  = 2098,
  parameter int SEG_TICKS = 4,
  parameter int CW        = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          sum_in,
  input  line_phase_t   phase_n,
  input  logic [CW-1:0] cnt_n,
  output logic          ph1_o,
  output logic          ph2_o,
  output logic          phs_o,
  output logic          tg1_o,
  output logic          tg2_o,
  output logic          nrst_o,
  output logic          pix_o,
  output logic          dark_o
);
  localparam logic [CW-1:0] SEG_1 = CW'(SEG_TICKS);
  localparam logic [CW-1:0] SEG_2 = CW'(2 * SEG_TICKS);
  localparam logic [CW-1:0] SEG_3 = CW'(3 * SEG_TICKS);
  localparam logic [CW-1:0] DARK_SHIFTS = CW'(N_DARK);

  logic          sum_q, sum_n;
  logic [CW-1:0] shift_idx;
  logic          ph1_n, ph2_n, phs_n, tg1_n, tg2_n, nrst_n, win_n, dark_n;

  always_comb begin
    sum_n     = load ? sum_in : sum_q;
    shift_idx = cnt_n >> 1;
    ph1_n  = 1'b1;
    ph2_n  = 1'b0;
    phs_n  = 1'b0;
    tg1_n  = 1'b0;
    tg2_n  = 1'b0;
    nrst_n = 1'b0;
    win_n  = 1'b0;
    dark_n = 1'b0;
    case (phase_n)
      PH_XFER: begin
        tg1_n = (cnt_n >= SEG_1) && (cnt_n < SEG_2);
        tg2_n = (cnt_n >= SEG_1) && (cnt_n < SEG_3);
      end
      PH_READ: begin
        ph1_n  = cnt_n[0];
        ph2_n  = ~cnt_n[0];
        dark_n = (shift_idx < DARK_SHIFTS);
        if (sum_n) begin
          phs_n  = (cnt_n[1:0] != 2'd3);
          nrst_n = (cnt_n[1:0] == 2'd2);
          win_n  = (cnt_n[1:0] == 2'd3);
        end else begin
          phs_n  = ~cnt_n[0];
          nrst_n = ~cnt_n[0];
          win_n  = cnt_n[0];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= 1'b0;
      ph1_o  <= 1'b1;
      ph2_o  <= 1'b0;
      phs_o  <= 1'b0;
      tg1_o  <= 1'b0;
      tg2_o  <= 1'b0;
      nrst_o <= 1'b0;
      pix_o  <= 1'b0;
      dark_o <= 1'b0;
    end else begin
      sum_q  <= sum_n;
      ph1_o  <= ph1_n;
      ph2_o  <= ph2_n;
      phs_o  <= phs_n;
      tg1_o  <= tg1_n;
      tg2_o  <= tg2_n;
      nrst_o <= nrst_n;
      pix_o  <= win_n & ~dark_n;
      dark_o <= win_n & dark_n;
    end
  end

  // R3
  phase_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(ph1_o && ph2_o));

  // R2
  tg_order_chk: assert property (@(posedge clk) disable iff (rst)
    tg1_o |-> tg2_o);

  // R2
  frozen_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    tg2_o |-> (ph1_o && !ph2_o && !phs_o));

  // R4
  reset_single_chk: assert property (@(posedge clk) disable iff (rst)
    nrst_o |=> !nrst_o);

  // R5
  window_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pix_o && dark_o));

  // R6
  full_mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sum_q |-> (phs_o == ph2_o));
endmodule

// File: rtl/ccd_exp_gate.sv
module ccd_exp_gate
  import ccd_tg_pkg::*;
#(
  parameter int EXP_W      = 13,
  parameter int READ_TICKS = 4220,
  parameter int CW         = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  line_phase_t      phase_n,
  input  logic [CW-1:0]    cnt_n,
  input  logic [EXP_W-1:0] exp_in,
  output logic             gate_o
);
  localparam int EW = (EXP_W > CW) ? EXP_W : CW;
  localparam logic [EW-1:0] READ_E = EW'(READ_TICKS);

  logic [EW-1:0] e_lat, e_nxt, e_clamped, remain;
  logic          gate_nxt;

  always_comb begin
    e_clamped = (EW'(exp_in) > READ_E) ? READ_E : EW'(exp_in);
    e_nxt     = load ? e_clamped : e_lat;
    remain    = READ_E - EW'(cnt_n);
    gate_nxt  = 1'b0;
    if (e_nxt != '0) begin
      case (phase_n)
        PH_XFER: gate_nxt = 1'b1;
        PH_READ: gate_nxt = (remain > e_nxt);
        default: gate_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_lat  <= '0;
      gate_o <= 1'b0;
    end else begin
      e_lat  <= e_nxt;
      gate_o <= gate_nxt;
    end
  end

  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (e_lat == '0) |-> !gate_o);

  // R9
  clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
    e_lat <= READ_E);
endmodule

// File: rtl/ccd_tri_timing.sv
module ccd_tri_timing
  import ccd_tg_pkg::*;
#(
  parameter int N_DARK    = 12,
  parameter int N_ACTIVE  = 2098,
  parameter int SEG_TICKS = 4,
  parameter int EXP_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             sum_mode,
  input  logic [EXP_W-1:0] exp_red,
  input  logic [EXP_W-1:0] exp_grn,
  input  logic [EXP_W-1:0] exp_blu,
  output logic             reg_ph1,
  output logic             reg_ph2,
  output logic             last_gate,
  output logic             xfer_g1,
  output logic             xfer_g2,
  output logic             node_rst,
  output logic [2:0]       exp_gate,
  output logic             pix_valid,
  output logic             dark_valid
);
  localparam int N_CHAN     = 3;
  localparam int READ_TICKS = 2 * (N_DARK + N_ACTIVE);
  localparam int XFER_TICKS = 4 * SEG_TICKS;
  localparam int MAX_TICKS  = (READ_TICKS > XFER_TICKS) ? READ_TICKS : XFER_TICKS;
  localparam int CW         = $clog2(MAX_TICKS + 1);

  logic          load;
  line_phase_t   phase_n;
  logic [CW-1:0] cnt_n;
  logic [EXP_W-1:0] exp_vals [N_CHAN];

  assign exp_vals[0] = exp_red;
  assign exp_vals[1] = exp_grn;
  assign exp_vals[2] = exp_blu;

  ccd_line_seq #(
    .XFER_TICKS(XFER_TICKS),
    .READ_TICKS(READ_TICKS),
    .CW        (CW)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (line_start),
    .load   (load),
    .phase_n(phase_n),
    .cnt_n  (cnt_n)
  );

  ccd_clock_gen #(
    .N_DARK   (N_DARK),
    .N_ACTIVE (N_ACTIVE),
    .SEG_TICKS(SEG_TICKS),
    .CW       (CW)
  ) u_clk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .sum_in (sum_mode),
    .phase_n(phase_n),
    .cnt_n  (cnt_n),
    .ph1_o  (reg_ph1),
    .ph2_o  (reg_ph2),
    .phs_o  (last_gate),
    .tg1_o  (xfer_g1),
    .tg2_o  (xfer_g2),
    .nrst_o (node_rst),
    .pix_o  (pix_valid),
    .dark_o (dark_valid)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    ccd_exp_gate #(
      .EXP_W     (EXP_W),
      .READ_TICKS(READ_TICKS),
      .CW        (CW)
    ) u_gate (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .phase_n(phase_n),
      .cnt_n  (cnt_n),
      .exp_in (exp_vals[c]),
      .gate_o (exp_gate[c])
    );

    // R8
    gate_fall_aligned_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(exp_gate[c]) |-> (reg_ph1 != $past(reg_ph1)));

    // R8
    gate_high_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
      (xfer_g1 && !exp_gate[c]) |=> !exp_gate[c]);
  end
endmodule

// File: tb/tb_ccd_tri_timing.sv
module tb_ccd_tri_timing;
  localparam int ND   = 4;
  localparam int NA   = 6;
  localparam int SEG  = 2;
  localparam int EW   = 8;
  localparam int XF   = 4 * SEG;
  localparam int RD   = 2 * (ND + NA);
  localparam int LINE = XF + RD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic sum_mode = 1'b0;
  logic [EW-1:0] exp_red = '0, exp_grn = '0, exp_blu = '0;
  logic reg_ph1, reg_ph2, last_gate, xfer_g1, xfer_g2, node_rst, pix_valid, dark_valid;
  logic [2:0] exp_gate;

  int n_check = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ccd_tri_timing #(.N_DARK(ND), .N_ACTIVE(NA), .SEG_TICKS(SEG), .EXP_W(EW)) dut (
    .clk(clk), .rst(rst), .line_start(line_start), .sum_mode(sum_mode),
    .exp_red(exp_red), .exp_grn(exp_grn), .exp_blu(exp_blu),
    .reg_ph1(reg_ph1), .reg_ph2(reg_ph2), .last_gate(last_gate),
    .xfer_g1(xfer_g1), .xfer_g2(xfer_g2), .node_rst(node_rst),
    .exp_gate(exp_gate), .pix_valid(pix_valid), .dark_valid(dark_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_check++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_check - n_fail, n_check);
  endtask

  // behavioural reference: tick index within line, -1 when idle
  int t = -1;
  int m_e[3];
  bit m_sum = 1'b0;

  function automatic int clampv(input int v);
    return (v > RD) ? RD : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t = -1;
    end else if (t < 0) begin
      if (line_start) begin
        t = 0;
        m_sum = sum_mode;
        m_e[0] = clampv(int'(exp_red));
        m_e[1] = clampv(int'(exp_grn));
        m_e[2] = clampv(int'(exp_blu));
      end
    end else if (t == LINE - 1) begin
      t = -1;
    end else begin
      t = t + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      int e_ph1, e_ph2, e_phs, e_tg1, e_tg2, e_nr, e_pix, e_dark;
      int e_g[3];
      e_ph1 = 1; e_ph2 = 0; e_phs = 0; e_tg1 = 0; e_tg2 = 0; e_nr = 0; e_pix = 0; e_dark = 0;
      for (int c = 0; c < 3; c++) e_g[c] = 0;
      if (t >= 0 && t < XF) begin
        e_tg1 = (t / SEG == 1) ? 1 : 0;
        e_tg2 = (t / SEG == 1 || t / SEG == 2) ? 1 : 0;
        for (int c = 0; c < 3; c++) e_g[c] = (m_e[c] != 0) ? 1 : 0;
      end else if (t >= XF) begin
        int r, win;
        r = t - XF;
        e_ph1 = r % 2;
        e_ph2 = 1 - (r % 2);
        if (m_sum) begin
          e_phs = (r % 4 != 3) ? 1 : 0;
          e_nr  = (r % 4 == 2) ? 1 : 0;
          win   = (r % 4 == 3) ? 1 : 0;
        end else begin
          e_phs = e_ph2;
          e_nr  = e_ph2;
          win   = r % 2;
        end
        e_dark = (win == 1 && (r / 2) < ND) ? 1 : 0;
        e_pix  = (win == 1 && (r / 2) >= ND) ? 1 : 0;
        for (int c = 0; c < 3; c++)
          e_g[c] = (m_e[c] != 0 && (RD - r) > m_e[c]) ? 1 : 0;
      end
      chk((t >= 0 && t < XF) ? "R2" : (t < 0 ? "R1" : "R3"), "reg_ph1", int'(reg_ph1), e_ph1);
      chk((t >= 0 && t < XF) ? "R2" : (t < 0 ? "R1" : "R3"), "reg_ph2", int'(reg_ph2), e_ph2);
      chk(m_sum ? "R7" : "R6", "last_gate", int'(last_gate), e_phs);
      chk("R2", "xfer_g1", int'(xfer_g1), e_tg1);
      chk("R2", "xfer_g2", int'(xfer_g2), e_tg2);
      chk(m_sum ? "R7" : "R4", "node_rst", int'(node_rst), e_nr);
      chk("R5", "pix_valid", int'(pix_valid), e_pix);
      chk("R5", "dark_valid", int'(dark_valid), e_dark);
      for (int c = 0; c < 3; c++)
        chk("R8", $sformatf("exp_gate[%0d]", c), int'(exp_gate[c]), e_g[c]);
    end
  end

  // Runs one line and counts windows and gate-high cycles.
  task automatic run_line(input bit sm, input int e0, input int e1, input int e2,
                          input bit disturb, output int np, output int nd, output int hg[3]);
    np = 0; nd = 0;
    for (int c = 0; c < 3; c++) hg[c] = 0;
    @(negedge clk);
    sum_mode = sm;
    exp_red = EW'(e0); exp_grn = EW'(e1); exp_blu = EW'(e2);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int i = 0; i < LINE + 2; i++) begin
      np += int'(pix_valid);
      nd += int'(dark_valid);
      for (int c = 0; c < 3; c++) hg[c] += int'(exp_gate[c]);
      if (disturb && i == 12) begin
        // R10 / R1: inputs rewritten and start pulsed mid-line
        sum_mode = ~sm;
        exp_red = 8'd0; exp_grn = 8'd3; exp_blu = 8'd200;
        line_start = 1'b1;
      end else begin
        line_start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int np, nd;
    int hg[3];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk("R1", "idle ph1", int'(reg_ph1), 1);
    chk("R1", "idle gates", int'({xfer_g1, xfer_g2, node_rst, exp_gate, pix_valid, dark_valid, last_gate}), 0);

    // R5, R8, R9: full mode, normal / zero / above-range exposure
    run_line(1'b0, 5, 0, 30, 1'b0, np, nd, hg);
    chk("R5", "full active windows", np, NA);
    chk("R5", "full dark windows", nd, ND);
    chk("R8", "gate0 high cycles", hg[0], LINE - 5);
    chk("R9", "zero exposure high cycles", hg[1], 0);
    chk("R9", "clamped exposure high cycles", hg[2], XF);

    // R7, R8, R9: summing mode, E=1, E=readout length, mid value
    run_line(1'b1, 1, RD, 12, 1'b0, np, nd, hg);
    chk("R7", "sum active windows", np, NA / 2);
    chk("R7", "sum dark windows", nd, ND / 2);
    chk("R8", "gate0 E=1 high cycles", hg[0], LINE - 1);
    chk("R9", "gate1 E=RD high cycles", hg[1], XF);
    chk("R10", "gate2 independent high cycles", hg[2], LINE - 12);

    // R10, R1: mid-line disturbance has no effect on the running line
    run_line(1'b0, 7, 9, 2, 1'b1, np, nd, hg);
    chk("R10", "disturbed active windows", np, NA);
    chk("R10", "disturbed dark windows", nd, ND);
    chk("R10", "disturbed gate0", hg[0], LINE - 7);
    chk("R10", "disturbed gate1", hg[1], LINE - 9);
    chk("R10", "disturbed gate2", hg[2], LINE - 2);

    // R1: start held high, lines back to back with one idle cycle
    @(negedge clk);
    sum_mode = 1'b1;
    exp_red = 8'd4; exp_grn = 8'd15; exp_blu = 8'd1;
    line_start = 1'b1;
    np = 0;
    for (int i = 0; i < 2 * LINE + 6; i++) begin
      @(negedge clk);
      np += int'(pix_valid);
    end
    line_start = 1'b0;
    chk("R1", "back-to-back active windows", np, NA);
    repeat (LINE + 4) @(negedge clk);
    chk("R1", "idle after lines", int'({reg_ph2, last_gate, exp_gate, node_rst}), 0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_check++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule